// File: doc/BRIEF.md
# Exception Entry and Return Stacking Sequencer

This block carries out the hardware part of taking and leaving an exception in a small processor core. When the interrupt controller presents an accepted exception number, the sequencer saves eight core registers to the stack as a fixed frame. It does this through a data-bus write port. In the same cycles it reads the handler address from the vector table through a separate instruction-bus read port. When the frame is written and the vector has arrived, it gives one result pulse. That pulse carries the new stack pointer, the handler address for the program counter, the return token for the link register and the status word with the exception number in its low field. The controller uses the pulse to mark the exception active and clear its pending state.

Return works the other way. A program-counter write whose value equals the return token starts an unstack. The sequencer reads the eight frame words back from the stack in ascending address order. It hands them to the register file with a second pulse and gives a stack pointer raised by 32 bytes. Both buses use a plain request/ready handshake, so memories with wait states may stall either one.

Top module: `exc_stack_seq`

## Requirements
- R1: After synchronous reset, busy, d_req, i_req, entry_done and exit_done are all 0.
- R2: When idle and exc_valid is high at a clock edge, the exception is accepted. The frame base is sp_in with bits [1:0] cleared, minus 32. Eight writes (d_we=1) store slot k at frame base + 4k, taken from ctx_in[32k+31:32k]. The slots are 0=R0, 1=R1, 2=R2, 3=R3, 4=R12, 5=LR, 6=PC and 7=status word. The writes go in descending address order, slot 7 first.
- R3: An entry makes exactly one instruction-bus read, at VEC_BASE + 4 x exception number. It is requested from the cycle after acceptance, in parallel with the first stack write.
- R4: entry_done is a one-cycle pulse. It comes after all eight writes and the vector read have completed, whichever finishes last. During that pulse sp_out equals the frame base and pc_out equals the word read from the vector table. lr_out equals RET_TOKEN. xpsr_out equals the stacked status word with bits [NUM_W-1:0] replaced by the exception number.
- R5: With both ready inputs held high, entry_done is high in the cycle that follows the eighth rising edge after the accepting edge, and low before that.
- R6: A bus request holds its address, direction and write data unchanged until ready is seen high at a clock edge.
- R7: While busy is high, exc_valid and program-counter writes are ignored. They produce no extra bus beat and no extra result pulse.
- R8: When idle, pc_wr_en with pc_wr_data equal to RET_TOKEN starts a return. Eight reads (d_we=0) fetch slot k from (sp_in with bits [1:0] cleared) + 4k, in ascending address order. exit_done then pulses for one cycle with ctx_out[32k+31:32k] equal to the word read for slot k, and sp_out equal to the aligned stack pointer plus 32.
- R9: A program-counter write with any value other than RET_TOKEN has no effect: busy and d_req stay 0.
- R10: If exc_valid and a return-token write arrive at the same idle edge, the entry is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Controller presents an accepted exception |
| exc_num | input | NUM_W | Exception number to enter |
| sp_in | input | 32 | Current stack pointer |
| ctx_in | input | 256 | Registers to stack, slot k in bits [32k+31:32k] |
| pc_wr_en | input | 1 | Core is writing the program counter |
| pc_wr_data | input | 32 | Value being written to the program counter |
| busy | output | 1 | A sequence is in progress |
| d_req | output | 1 | Data-bus request |
| d_we | output | 1 | Data-bus write (1) or read (0) |
| d_addr | output | 32 | Data-bus word address |
| d_wdata | output | 32 | Data-bus write data |
| d_rdata | input | 32 | Data-bus read data |
| d_ready | input | 1 | Data-bus beat completes at this edge |
| i_req | output | 1 | Instruction-bus read request for the vector |
| i_addr | output | 32 | Vector table address |
| i_rdata | input | 32 | Vector read data |
| i_ready | input | 1 | Instruction-bus read completes at this edge |
| entry_done | output | 1 | One-cycle pulse: entry finished |
| exit_done | output | 1 | One-cycle pulse: return finished |
| sp_out | output | 32 | New stack pointer, valid with either pulse |
| pc_out | output | 32 | Handler address, valid with entry_done |
| lr_out | output | 32 | Return token, valid with entry_done |
| xpsr_out | output | 32 | Status word with new exception number, valid with entry_done |
| ctx_out | output | 256 | Restored frame, valid with exit_done |

## Verification
A wrong beat counter or slot mapping shows on the data bus at once. It puts a word at the wrong address or in the wrong order on the very beat where it goes wrong, and the bus scoreboard compares each beat as it happens. A wrong join between the vector read and the stack writes shows as entry_done arriving early, with a stale pc_out, or never arriving. Stalling one bus at a time exposes this within the same entry. A corrupted stacked word only shows when the frame is read back. So every stored frame is later unstacked and compared, some several entries afterwards, to catch writes that landed on another frame.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int WORD_W      = 32;
    localparam int FRAME_WORDS = 8;
    localparam int SLOT_W      = $clog2(FRAME_WORDS);
    localparam int FRAME_BYTES = FRAME_WORDS * 4;
    localparam int FRAME_BITS  = FRAME_WORDS * WORD_W;

    // Slot numbering inside the frame, lowest address first.
    localparam int SLOT_R0   = 0;
    localparam int SLOT_R12  = 4;
    localparam int SLOT_LR   = 5;
    localparam int SLOT_PC   = 6;
    localparam int SLOT_XPSR = 7;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [FRAME_WORDS-1:0] frame_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ENTRY = 2'd1,
        SQ_EXIT  = 2'd2
    } seq_state_e;

    typedef enum logic {
        MV_PUSH = 1'b0,
        MV_POP  = 1'b1
    } mv_dir_e;

    typedef struct packed {
        word_t base;      // lowest address of the frame
        word_t sp_after;  // stack pointer reported at completion
    } frame_ptr_t;

    function automatic word_t align_word(input word_t a);
        return {a[WORD_W-1:2], 2'b00};
    endfunction

    function automatic word_t slot_addr(input word_t base, input logic [SLOT_W-1:0] s);
        return base + (word_t'(s) << 2);
    endfunction

    function automatic word_t vec_addr(input word_t table_base, input word_t idx);
        return table_base + (idx << 2);
    endfunction

    function automatic frame_ptr_t make_ptr(input word_t sp, input logic popping);
        frame_ptr_t p;
        if (popping) begin
            p.base     = align_word(sp);
            p.sp_after = align_word(sp) + word_t'(FRAME_BYTES);
        end else begin
            p.base     = align_word(sp) - word_t'(FRAME_BYTES);
            p.sp_after = align_word(sp) - word_t'(FRAME_BYTES);
        end
        return p;
    endfunction

endpackage

// File: rtl/exc_frame_mover.sv
module exc_frame_mover
    import exc_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  mv_dir_e dir,
    input  word_t   base,
    input  frame_t  wframe,
    output logic    d_req,
    output logic    d_we,
    output word_t   d_addr,
    output word_t   d_wdata,
    input  word_t   d_rdata,
    input  logic    d_ready,
    output logic    finished,
    output frame_t  rframe
);

    localparam logic [SLOT_W-1:0] LAST_BEAT = SLOT_W'(FRAME_WORDS - 1);

    logic              run_q;
    mv_dir_e           dir_q;
    logic [SLOT_W-1:0] beat_q;
    logic              fin_q;
    logic [SLOT_W-1:0] slot;
    logic              xfer;

    // Pushes walk from the top slot down, pops walk upward.
    assign slot = (dir_q == MV_POP) ? beat_q : (LAST_BEAT - beat_q);
    assign xfer = run_q && d_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            dir_q  <= MV_PUSH;
            beat_q <= '0;
            fin_q  <= 1'b0;
            rframe <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            dir_q  <= dir;
            beat_q <= '0;
            fin_q  <= 1'b0;
        end else if (xfer) begin
            if (dir_q == MV_POP) begin
                rframe[slot] <= d_rdata;
            end
            if (beat_q == LAST_BEAT) begin
                run_q <= 1'b0;
                fin_q <= 1'b1;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign d_req    = run_q;
    assign d_we     = run_q && (dir_q == MV_PUSH);
    assign d_addr   = slot_addr(base, slot);
    assign d_wdata  = wframe[slot];
    assign finished = fin_q;

    // R6: a stalled data beat keeps its address, direction and data
    a_r6_dbus_hold: assert property (@(posedge clk) disable iff (rst)
        (d_req && !d_ready) |=> (d_req && $stable(d_addr) && $stable(d_we) && $stable(d_wdata)));

    // R2: every beat addresses a whole word
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
        d_req |-> (d_addr[1:0] == 2'b00));

    // R2 / R8: once finished, no further beat until restarted
    a_r2_quiet_after_fin: assert property (@(posedge clk) disable iff (rst)
        (fin_q && !start) |=> !d_req);

endmodule

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch
    import exc_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t addr,
    output logic  i_req,
    output word_t i_addr,
    input  word_t i_rdata,
    input  logic  i_ready,
    output logic  have,
    output word_t vec
);

    logic  pend_q;
    logic  have_q;
    word_t addr_q;
    word_t vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            have_q <= 1'b0;
            addr_q <= '0;
            vec_q  <= '0;
        end else if (start) begin
            pend_q <= 1'b1;
            have_q <= 1'b0;
            addr_q <= addr;
        end else if (pend_q && i_ready) begin
            pend_q <= 1'b0;
            have_q <= 1'b1;
            vec_q  <= i_rdata;
        end
    end

    assign i_req  = pend_q;
    assign i_addr = addr_q;
    assign have   = have_q;
    assign vec    = vec_q;

    // R6: a stalled vector read keeps its address
    a_r6_ibus_hold: assert property (@(posedge clk) disable iff (rst)
        (i_req && !i_ready) |=> (i_req && $stable(i_addr)));

    // R3: a single read per entry; a held vector issues no further request
    a_r3_single_read: assert property (@(posedge clk) disable iff (rst)
        have |-> !i_req);

endmodule

// File: rtl/exc_stack_seq.sv
module exc_stack_seq
    import exc_seq_pkg::*;
#(
    parameter int          NUM_W     = 9,
    parameter logic [31:0] VEC_BASE  = 32'h0000_0000,
    parameter logic [31:0] RET_TOKEN = 32'hFFFF_FFF9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  exc_valid,
    input  logic [NUM_W-1:0]      exc_num,
    input  logic [WORD_W-1:0]     sp_in,
    input  logic [FRAME_BITS-1:0] ctx_in,
    input  logic                  pc_wr_en,
    input  logic [WORD_W-1:0]     pc_wr_data,
    output logic                  busy,
    output logic                  d_req,
    output logic                  d_we,
    output logic [WORD_W-1:0]     d_addr,
    output logic [WORD_W-1:0]     d_wdata,
    input  logic [WORD_W-1:0]     d_rdata,
    input  logic                  d_ready,
    output logic                  i_req,
    output logic [WORD_W-1:0]     i_addr,
    input  logic [WORD_W-1:0]     i_rdata,
    input  logic                  i_ready,
    output logic                  entry_done,
    output logic                  exit_done,
    output logic [WORD_W-1:0]     sp_out,
    output logic [WORD_W-1:0]     pc_out,
    output logic [WORD_W-1:0]     lr_out,
    output logic [WORD_W-1:0]     xpsr_out,
    output logic [FRAME_BITS-1:0] ctx_out
);

    seq_state_e       st_q;
    logic [NUM_W-1:0] num_q;
    frame_t           frame_q;
    frame_ptr_t       ptr_q;

    logic       ret_hit;
    logic       go_entry;
    logic       go_exit;
    logic       fin_entry;
    logic       fin_exit;
    frame_ptr_t ptr_next;

    logic   mv_fin;
    frame_t mv_rframe;
    logic   vf_have;
    word_t  vf_vec;

    assign ret_hit  = pc_wr_en && (pc_wr_data == RET_TOKEN);
    // Entry outranks a return offered at the same edge.
    assign go_entry = (st_q == SQ_IDLE) && exc_valid;
    assign go_exit  = (st_q == SQ_IDLE) && !exc_valid && ret_hit;
    assign ptr_next = make_ptr(sp_in, go_exit);

    // The join: both the frame writes and the vector must be in hand.
    assign fin_entry = (st_q == SQ_ENTRY) && mv_fin && vf_have;
    assign fin_exit  = (st_q == SQ_EXIT) && mv_fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            num_q   <= '0;
            frame_q <= '0;
            ptr_q   <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    if (go_entry) begin
                        st_q    <= SQ_ENTRY;
                        num_q   <= exc_num;
                        frame_q <= ctx_in;
                        ptr_q   <= ptr_next;
                    end else if (go_exit) begin
                        st_q  <= SQ_EXIT;
                        ptr_q <= ptr_next;
                    end
                end
                SQ_ENTRY: if (fin_entry) st_q <= SQ_IDLE;
                SQ_EXIT:  if (fin_exit)  st_q <= SQ_IDLE;
                default:  st_q <= SQ_IDLE;
            endcase
        end
    end

    exc_frame_mover u_mover (
        .clk      (clk),
        .rst      (rst),
        .start    (go_entry || go_exit),
        .dir      (go_exit ? MV_POP : MV_PUSH),
        .base     (ptr_q.base),
        .wframe   (frame_q),
        .d_req    (d_req),
        .d_we     (d_we),
        .d_addr   (d_addr),
        .d_wdata  (d_wdata),
        .d_rdata  (d_rdata),
        .d_ready  (d_ready),
        .finished (mv_fin),
        .rframe   (mv_rframe)
    );

    exc_vec_fetch u_vec (
        .clk     (clk),
        .rst     (rst),
        .start   (go_entry),
        .addr    (vec_addr(VEC_BASE, word_t'(exc_num))),
        .i_req   (i_req),
        .i_addr  (i_addr),
        .i_rdata (i_rdata),
        .i_ready (i_ready),
        .have    (vf_have),
        .vec     (vf_vec)
    );

    assign busy       = (st_q != SQ_IDLE);
    assign entry_done = fin_entry;
    assign exit_done  = fin_exit;
    assign sp_out     = ptr_q.sp_after;
    assign pc_out     = vf_vec;
    assign lr_out     = RET_TOKEN;
    assign xpsr_out   = {frame_q[SLOT_XPSR][WORD_W-1:NUM_W], num_q};
    assign ctx_out    = mv_rframe;

    // R4: completion strobes last exactly one cycle
    a_r4_entry_pulse: assert property (@(posedge clk) disable iff (rst)
        entry_done |=> !entry_done);

    // R8: return strobe lasts exactly one cycle
    a_r8_exit_pulse: assert property (@(posedge clk) disable iff (rst)
        exit_done |=> !exit_done);

    // R4: both buses are quiet when entry completes
    a_r4_join_both: assert property (@(posedge clk) disable iff (rst)
        entry_done |-> (!d_req && !i_req));

    // R7: a sequence can only start from an offered request
    a_r7_start_source: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(exc_valid || ret_hit));

    // R10: simultaneous entry and return offer starts a stack write
    a_r10_entry_first: assert property (@(posedge clk) disable iff (rst)
        (!busy && exc_valid && ret_hit) |=> (d_req && d_we));

    // R9: a non-token program-counter write alone starts nothing
    a_r9_plain_pc_write: assert property (@(posedge clk) disable iff (rst)
        (!busy && !exc_valid && pc_wr_en && (pc_wr_data != RET_TOKEN)) |=> !busy);

    // R3: the vector read targets the table slot of the latched number
    a_r3_vec_slot: assert property (@(posedge clk) disable iff (rst)
        i_req |-> (i_addr == VEC_BASE + ({{(WORD_W-NUM_W){1'b0}}, num_q} << 2)));

endmodule

// File: tb/exc_stack_seq_tb.sv
module exc_stack_seq_tb;
    import exc_seq_pkg::*;

    localparam int          NUM_W = 9;
    localparam logic [31:0] VBASE = 32'h0000_0400;
    localparam logic [31:0] TOKEN = 32'hFFFF_FFF9;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                  rst = 1'b1;
    logic                  exc_valid = 1'b0;
    logic [NUM_W-1:0]      exc_num = '0;
    logic [31:0]           sp_in = '0;
    logic [FRAME_BITS-1:0] ctx_in = '0;
    logic                  pc_wr_en = 1'b0;
    logic [31:0]           pc_wr_data = '0;
    logic                  busy, d_req, d_we, d_ready, i_req, i_ready;
    logic [31:0]           d_addr, d_wdata, d_rdata, i_addr, i_rdata;
    logic                  entry_done, exit_done;
    logic [31:0]           sp_out, pc_out, lr_out, xpsr_out;
    logic [FRAME_BITS-1:0] ctx_out;

    exc_stack_seq #(.NUM_W(NUM_W), .VEC_BASE(VBASE), .RET_TOKEN(TOKEN)) u_dut (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_num(exc_num), .sp_in(sp_in),
        .ctx_in(ctx_in), .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .busy(busy),
        .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata),
        .d_ready(d_ready), .i_req(i_req), .i_addr(i_addr), .i_rdata(i_rdata),
        .i_ready(i_ready), .entry_done(entry_done), .exit_done(exit_done), .sp_out(sp_out),
        .pc_out(pc_out), .lr_out(lr_out), .xpsr_out(xpsr_out), .ctx_out(ctx_out)
    );

    // Memory and bus responders
    logic [31:0] mem [0:255];
    logic [15:0] lfsr  = 16'hACE1;
    logic        dstall = 1'b0;
    int          idelay = 0;
    int          iwait  = 0;

    function automatic logic [31:0] tb_vec(input logic [31:0] a);
        return (a * 3) + 32'h0800_0001;
    endfunction

    assign d_rdata = mem[d_addr[9:2]];
    assign d_ready = dstall ? lfsr[0] : 1'b1;
    assign i_ready = i_req && (iwait >= idelay);
    assign i_rdata = tb_vec(i_addr);

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (i_req && !i_ready) iwait <= iwait + 1;
        else                   iwait <= 0;
        if (d_req && d_ready && d_we) mem[d_addr[9:2]] <= d_wdata;
    end

    // Scoreboard
    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic        we;
    } bus_exp_t;

    typedef struct {
        logic                  is_exit;
        logic [31:0]           sp;
        logic [31:0]           pc;
        logic [31:0]           xpsr;
        logic [FRAME_BITS-1:0] ctx;
    } res_exp_t;

    bus_exp_t    bq[$];
    res_exp_t    rq[$];
    logic [31:0] iq[$];
    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input string what,
                       input logic [FRAME_BITS-1:0] act, input logic [FRAME_BITS-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (d_req && d_ready) begin : dbeat
                bus_exp_t e;
                if (bq.size() == 0) begin
                    chk("R7", "unexpected data beat addr", 256'(d_addr), 256'(0));
                end else begin
                    e = bq.pop_front();
                    chk(e.we ? "R2" : "R8", "beat dir", 256'(d_we), 256'(e.we));
                    chk(e.we ? "R2" : "R8", "beat addr", 256'(d_addr), 256'(e.addr));
                    if (e.we) chk("R2", "beat data", 256'(d_wdata), 256'(e.data));
                end
            end
            if (i_req && i_ready) begin
                if (iq.size() == 0) chk("R3", "unexpected vector read", 256'(i_addr), 256'(0));
                else                chk("R3", "vector addr", 256'(i_addr), 256'(iq.pop_front()));
            end
            if (entry_done || exit_done) begin : res
                res_exp_t r;
                if (rq.size() == 0) begin
                    chk("R7", "unexpected result pulse", 256'({entry_done, exit_done}), 256'(0));
                end else begin
                    r = rq.pop_front();
                    chk("R10", "result kind", 256'(exit_done), 256'(r.is_exit));
                    chk(r.is_exit ? "R8" : "R4", "sp_out", 256'(sp_out), 256'(r.sp));
                    if (r.is_exit) begin
                        chk("R8", "ctx_out", ctx_out, r.ctx);
                    end else begin
                        chk("R4", "pc_out", 256'(pc_out), 256'(r.pc));
                        chk("R4", "lr_out", 256'(lr_out), 256'(TOKEN));
                        chk("R4", "xpsr_out", 256'(xpsr_out), 256'(r.xpsr));
                    end
                end
            end
        end
    end

    // Driver tasks: start at a negedge, return at the negedge after the accepting edge
    task automatic do_entry(input logic [NUM_W-1:0] num, input logic [31:0] sp,
                            input logic [FRAME_BITS-1:0] ctx);
        logic [31:0] base;
        bus_exp_t    b;
        res_exp_t    r;
        base = {sp[31:2], 2'b00} - 32'd32;
        for (int k = 7; k >= 0; k--) begin
            b.addr = base + 32'(4 * k);
            b.data = ctx[32*k +: 32];
            b.we   = 1'b1;
            bq.push_back(b);
        end
        iq.push_back(VBASE + 32'(4 * num));
        r.is_exit = 1'b0;
        r.sp      = base;
        r.pc      = tb_vec(VBASE + 32'(4 * num));
        r.xpsr    = {ctx[255:224+NUM_W], num};
        r.ctx     = '0;
        rq.push_back(r);
        exc_valid = 1'b1;
        exc_num   = num;
        sp_in     = sp;
        ctx_in    = ctx;
        @(posedge clk);
        @(negedge clk);
        exc_valid = 1'b0;
    endtask

    task automatic do_exit(input logic [31:0] sp, input logic [FRAME_BITS-1:0] exp_ctx);
        logic [31:0] al;
        bus_exp_t    b;
        res_exp_t    r;
        al = {sp[31:2], 2'b00};
        for (int k = 0; k < 8; k++) begin
            b.addr = al + 32'(4 * k);
            b.data = '0;
            b.we   = 1'b0;
            bq.push_back(b);
        end
        r.is_exit = 1'b1;
        r.sp      = al + 32'd32;
        r.pc      = '0;
        r.xpsr    = '0;
        r.ctx     = exp_ctx;
        rq.push_back(r);
        sp_in      = sp;
        pc_wr_en   = 1'b1;
        pc_wr_data = TOKEN;
        @(posedge clk);
        @(negedge clk);
        pc_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [FRAME_BITS-1:0] mk_ctx(input logic [7:0] seed);
        logic [FRAME_BITS-1:0] c;
        for (int k = 0; k < 8; k++) c[32*k +: 32] = {seed, 8'(k), 16'hC0DE ^ {seed, 8'(k)}};
        return c;
    endfunction

    initial begin
        logic [FRAME_BITS-1:0] ca, cb, cc, cd, ce;
        ca = mk_ctx(8'hA1); cb = mk_ctx(8'hB2); cc = mk_ctx(8'hC3);
        cd = mk_ctx(8'hD4); ce = mk_ctx(8'hE5);

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", 256'(busy), 256'(0));
        chk("R1", "d_req", 256'(d_req), 256'(0));
        chk("R1", "i_req", 256'(i_req), 256'(0));
        chk("R1", "done strobes", 256'({entry_done, exit_done}), 256'(0));
        rst = 1'b0;
        @(negedge clk);

        // R5: zero-wait entry latency, number 16
        do_entry(9'd16, 32'h2000_0300, ca);
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R5", $sformatf("entry_done after edge %0d", k), 256'(entry_done), 256'(k == 8));
        end
        wait_idle();

        // R3 / R4: vector arrives early, data bus stalls; unaligned stack pointer
        dstall = 1'b1; idelay = 0;
        do_entry(9'd3, 32'h2000_0283, cb);
        wait_idle();

        // R4: vector arrives after the last write
        dstall = 1'b0; idelay = 14;
        do_entry(9'd45, 32'h2000_0200, cc);
        wait_idle();

        // R8: zero-wait return of frame C, with latency
        idelay = 0;
        do_exit(32'h2000_01E0, cc);
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R8", $sformatf("exit_done after edge %0d", k), 256'(exit_done), 256'(k == 8));
        end
        wait_idle();

        // R8 / R6: stalled return of frame B
        dstall = 1'b1;
        do_exit(32'h2000_0260, cb);
        wait_idle();

        // R7: requests offered while busy are dropped
        do_entry(9'd7, 32'h2000_0380, cd);
        while (busy) begin
            exc_valid = 1'b1; exc_num = 9'd99; pc_wr_en = 1'b1; pc_wr_data = TOKEN;
            @(negedge clk);
        end
        exc_valid = 1'b0; pc_wr_en = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk("R7", "busy after ignored requests", 256'(busy), 256'(0));
            chk("R7", "d_req after ignored requests", 256'(d_req), 256'(0));
        end

        // R9: ordinary program-counter write
        pc_wr_en = 1'b1; pc_wr_data = 32'h0000_1234;
        @(posedge clk);
        @(negedge clk);
        pc_wr_en = 1'b0;
        chk("R9", "busy", 256'(busy), 256'(0));
        chk("R9", "d_req", 256'(d_req), 256'(0));

        // R10: entry and return offered together
        dstall = 1'b0;
        pc_wr_en = 1'b1; pc_wr_data = TOKEN;
        do_entry(9'd20, 32'h2000_0100, ce);
        pc_wr_en = 1'b0;
        chk("R10", "first beat is a write", 256'({d_req, d_we}), 256'(3));
        wait_idle();

        // R8: late returns of frames D, A, E
        dstall = 1'b1;
        do_exit(32'h2000_0360, cd);
        wait_idle();
        dstall = 1'b0;
        do_exit(32'h2000_02E0, ca);
        wait_idle();
        do_exit(32'h2000_00E0, ce);
        wait_idle();

        repeat (3) @(negedge clk);
        chk("R4", "results outstanding", 256'(rq.size()), 256'(0));
        chk("R2", "beats outstanding", 256'(bq.size()), 256'(0));
        chk("R3", "vector reads outstanding", 256'(iq.size()), 256'(0));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule